// File: doc/BRIEF.md
# Slot-Mask Bundle Expander

This block turns a compressed wide-issue fetch packet back into a full eight-slot issue bundle. A packet carries an 8-bit occupancy mask and a dense list of up to eight operation words. Every mask bit that is set marks a slot that takes the next operation from the dense list. Every clear bit marks a slot that is filled with a no-operation word. The mask costs a fixed eight bits on every bundle, however many operations the packet holds.

Each slot finds its operation by counting the set mask bits to its left, which is a prefix popcount. The slots therefore need no serial walk through the list, and the whole bundle forms in a single cycle. The result is registered. A valid/ready pair on each side moves one packet in and one bundle out. When the consumer stalls, the bundle stays put and intake stops. A count of consumed operation words comes out alongside the bundle, so the fetch stage knows how far to advance.

Top module: `slot_mask_expander`

## Requirements
- R1: Slot s (0 to 7) holds the no-operation word NOP_VAL (default all zeros) whenever mask bit 7-s is 0. The leftmost mask bit, bit 7, controls slot 0.
- R2: The dense operation words go to the active slots in list order, so active slot s holds word number (count of set mask bits 7 down to 8-s). For example, mask 8'hA7 with words A..E gives A, NOP, B, NOP, NOP, C, D, E in slots 0..7.
- R3: `out_used` equals the number of set bits in the mask of the packet that produced the bundle.
- R4: An all-zero mask yields eight NOP_VAL slots and `out_used` of 0.
- R5: An all-ones mask yields slot s equal to dense word s for every s.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_slots`, `out_used` and `out_valid` stay unchanged.
- R7: During reset and at the first edge after reset, `out_valid` is 0 and `in_ready` is 1.
- R8: Dense words whose index is at or beyond the mask's popcount have no effect on the bundle.
- R9: A packet is accepted at an edge where `in_valid` and `in_ready` are both high. Its bundle appears with `out_valid` high after that edge. With no new packet arriving, `out_valid` drops after an edge at which `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet can be taken |
| in_mask | input | 8 | Slot occupancy mask; bit 7 controls slot 0 |
| in_ops | input | 8*OP_W | Dense operation list; word k at bits [k*OP_W +: OP_W] |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_slots | output | 8*OP_W | Expanded bundle; slot s at bits [s*OP_W +: OP_W] |
| out_used | output | 4 | Number of dense words consumed |

## Verification
The properties assume that `in_mask` and `in_ops` hold steady and are known whenever `in_valid` is high. The stall properties also need `out_ready` to be a plain level that the design does not loop back on. The bench changes inputs only on falling edges and keeps the packet fields constant while it waits for acceptance. Dense words beyond the popcount are filled with varied non-zero values, so an expander that used them would produce a visibly wrong bundle.

// File: rtl/slot_mask_expander.sv
module slot_mask_expander #(
  parameter int OP_W = 32,
  parameter logic [OP_W-1:0] NOP_VAL = '0,
  localparam int SLOTS = 8,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SLOTS-1:0]      in_mask,
  input  logic [SLOTS*OP_W-1:0] in_ops,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SLOTS*OP_W-1:0] out_slots,
  output logic [CNT_W-1:0]      out_used
);

  function automatic logic [CNT_W-1:0] ones(input logic [SLOTS-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < SLOTS; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic                  take;
  logic [SLOTS*OP_W-1:0] bundle;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [SLOTS-1:0] LEFT = ~({SLOTS{1'b1}} >> s);
    logic [CNT_W-1:0] pick;
    assign pick = ones(in_mask & LEFT);
    assign bundle[s*OP_W +: OP_W] =
      in_mask[SLOTS-1-s] ? in_ops[int'(pick)*OP_W +: OP_W] : NOP_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_slots <= {SLOTS{NOP_VAL}};
      out_used  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_slots <= bundle;
      out_used  <= ones(in_mask);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/slot_mask_expander_chk.sv
module slot_mask_expander_chk #(
  parameter int OP_W = 32,
  parameter logic [OP_W-1:0] NOP_VAL = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [7:0]      in_mask,
  input logic [8*OP_W-1:0] in_ops,
  input logic            out_valid,
  input logic            out_ready,
  input logic [8*OP_W-1:0] out_slots,
  input logic [3:0]      out_used
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slots) && $stable(out_used));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_used == $past(4'($countones(in_mask))));

  p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mask == 8'h00 |=> out_used == 4'd0 && out_slots == {8{NOP_VAL}});

  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_mask == 8'hFF |=> out_slots == $past(in_ops));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid && in_ready);

  for (genvar s = 0; s < 8; s++) begin : g_nop
    p_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !in_mask[7-s] |=> out_slots[s*OP_W +: OP_W] == NOP_VAL);
  end
endmodule

bind slot_mask_expander slot_mask_expander_chk #(.OP_W(OP_W), .NOP_VAL(NOP_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mask(in_mask), .in_ops(in_ops), .out_valid(out_valid),
  .out_ready(out_ready), .out_slots(out_slots), .out_used(out_used)
);

// File: tb/test_slot_mask_expander.sv
module test_slot_mask_expander;
  localparam int W = 16;
  localparam int NV = 8;
  localparam logic [7:0] MASKS [NV] = '{8'hA7, 8'h00, 8'hFF, 8'h80, 8'h01, 8'h5A, 8'h3C, 8'hE1};
  localparam int USED [NV] = '{5, 0, 8, 1, 1, 4, 4, 4};

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [7:0] in_mask = '0;
  logic [8*W-1:0] in_ops = '0, out_slots, exp_b, held_b;
  logic [3:0] out_used, held_u;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  slot_mask_expander #(.OP_W(W)) i_slot_mask_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_ops(in_ops), .out_valid(out_valid),
    .out_ready(out_ready), .out_slots(out_slots), .out_used(out_used));

  task automatic check(input bit ok, input string tag, input logic [8*W-1:0] act, input logic [8*W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8*W-1:0] model(input logic [7:0] m, input logic [8*W-1:0] ops);
    logic [8*W-1:0] b;
    int k;
    k = 0;
    for (int s = 0; s < 8; s++) begin
      if (m[7-s]) begin
        b[s*W +: W] = ops[k*W +: W];
        k++;
      end else b[s*W +: W] = '0;
    end
    return b;
  endfunction

  task automatic send(input logic [7:0] m, input logic [8*W-1:0] ops);
    @(negedge clk);
    in_mask = m; in_ops = ops; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [8*W-1:0] fill(input int seed);
    logic [8*W-1:0] o;
    for (int k = 0; k < 8; k++) o[k*W +: W] = 16'h0101 + {8'(seed), 8'(k * 17)};
    return o;
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [8*W-1:0] ops;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R7 in reset", {126'd0, out_valid, in_ready}, 128'd1);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R7 after reset", {126'd0, out_valid, in_ready}, 128'd1);

    for (int i = 0; i < NV; i++) begin
      ops = fill(i + 1);
      send(MASKS[i], ops);
      exp_b = model(MASKS[i], ops);
      check(out_valid, "R9 valid after accept", 128'(out_valid), 128'd1);
      check(out_slots == exp_b, $sformatf("R1/R2 mask %h", MASKS[i]), out_slots, exp_b);
      check(out_used == 4'(USED[i]), "R3 used count", 128'(out_used), 128'(USED[i]));
    end

    // R2 worked example A..E
    ops = {48'h0, 16'h000E, 16'h000D, 16'h000C, 16'h000B, 16'h000A};
    send(8'hA7, ops);
    exp_b = {16'h000E, 16'h000D, 16'h000C, 16'h0, 16'h0, 16'h000B, 16'h0, 16'h000A};
    check(out_slots == exp_b, "R2 example A7", out_slots, exp_b);

    // R4 all-zero mask with busy dense list
    send(8'h00, fill(77));
    check(out_slots == '0 && out_used == 0, "R4 empty mask", out_slots, 128'd0);

    // R5 all ones
    ops = fill(9);
    send(8'hFF, ops);
    check(out_slots == ops, "R5 full mask", out_slots, ops);

    // R8 unused words ignored
    ops = fill(3);
    send(8'hC0, ops);
    held_b = out_slots;
    ops[8*W-1:2*W] = ~ops[8*W-1:2*W];
    send(8'hC0, ops);
    check(out_slots == held_b, "R8 tail words ignored", out_slots, held_b);

    // R9 drain
    @(negedge clk);
    check(!out_valid, "R9 drop after take", 128'(out_valid), 128'd0);

    // R6 backpressure
    out_ready = 0;
    ops = fill(40);
    send(8'h96, ops);
    held_b = out_slots; held_u = out_used;
    @(negedge clk);
    in_mask = 8'hFF; in_ops = fill(50); in_valid = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(!in_ready && out_valid, "R6 stall ready", {126'd0, in_ready, out_valid}, 128'd1);
      check(out_slots == held_b && out_used == held_u, "R6 held bundle", out_slots, held_b);
    end
    check(held_b == model(8'h96, ops), "R6 stalled content", held_b, model(8'h96, ops));
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check(out_slots == fill(50) && out_used == 8, "R6 release takes next", out_slots, fill(50));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule